// File: doc/BRIEF.md
# Dual-Issue Pairing Check

This block sits at the issue point of an in-order pipeline that fetches two instructions per cycle. The pair arrives already decoded: each slot carries a three-bit class and a ready flag that the scoreboard derives from resource and dependency state. The block decides, in the same cycle, whether both instructions go, only the older one goes, or nothing goes. The decision rests on a fixed pairing table, which reflects the read and write port limits of the register files.

When the older instruction issues and the younger one cannot go with it, the younger one is moved into a one-entry leftover register. On the following cycles it is presented alone, with its own ready flag, and the front end is held until it has issued. When the older instruction itself is not ready, nothing issues and the front end keeps presenting the same pair.

Top module: `dual_issue_pair`

## Requirements
- R1: After synchronous active-high reset, with no pair presented, the leftover register is empty, neither slot fires and the front-end stall is low.
- R2: Class codes are: 0 integer operate, 1 FP operate, 2 load, 3 integer store, 4 FP store, 5 integer branch, 6 FP branch, 7 none. When both slots are ready, both fire in the same cycle for exactly these unordered pairs: integer operate with FP operate, load with either operate, integer store with integer operate, FP store with FP operate, integer operate with integer branch, and FP operate with FP branch.
- R3: An integer operate with an FP store, and an FP operate with an integer store, in either slot order, never fire together; only the older one fires.
- R4: Any pair not listed in R2 (such as two loads, two integer operates, or two branches) fires only the older instruction.
- R5: Issue is in order: the younger slot never fires unless the older slot fires in the same cycle.
- R6: When the older instruction of a presented pair is not ready, nothing fires, the stall is high, and no leftover is stored.
- R7: When the older instruction fires and a real younger instruction does not, the younger one is held; from the next cycle it is presented alone on the older issue outputs with its class, the younger slot outputs show class 7 and never fire, and the stall stays high.
- R8: A held instruction fires in the cycle its hold-ready input is high, and the leftover register is empty on the next cycle; while hold-ready is low, it stays held with an unchanged class.
- R9: While an instruction is held, the presented pair and its ready flags have no effect on the outputs.
- R10: A pair whose younger class is 7 fires its older instruction alone with no leftover and no stall; a pair whose older class is 7, or an invalid pair, fires nothing and raises no stall.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pair_valid | input | 1 | A decoded pair is presented |
| slot0_cls | input | 3 | Class of the older instruction |
| slot0_rdy | input | 1 | Older instruction has its resources and operands |
| slot1_cls | input | 3 | Class of the younger instruction |
| slot1_rdy | input | 1 | Younger instruction has its resources and operands |
| hold_rdy | input | 1 | Held instruction has its resources and operands |
| iss0_fire | output | 1 | Older issue position fires this cycle |
| iss0_cls | output | 3 | Class presented in the older issue position |
| iss1_fire | output | 1 | Younger issue position fires this cycle |
| iss1_cls | output | 3 | Class presented in the younger issue position |
| fe_stall | output | 1 | Front end must hold its current pair |
| hold_valid | output | 1 | Leftover register holds an instruction |

## Verification
Every ordered combination of the seven real classes is presented with both slots ready, which separates the legal pairs from the two forbidden cross-unit pairs and from the unlisted ones, and checks that slot order does not change the verdict. Each split pair is then drained through the leftover register, which shows that the younger class is the one presented alone. Separate patterns hold the leftover with its ready flag low while a different pair is driven, stall the older slot, leave the younger slot not ready on a legal pair, and use the none class in each slot; together these distinguish a stall from a split and show that presented inputs are ignored while a leftover waits.

// File: rtl/dual_issue_pkg.sv
package dual_issue_pkg;

    localparam int CLS_W = 3;

    typedef enum logic [CLS_W-1:0] {
        CLS_IOP  = 3'd0,
        CLS_FOP  = 3'd1,
        CLS_LD   = 3'd2,
        CLS_IST  = 3'd3,
        CLS_FST  = 3'd4,
        CLS_IBR  = 3'd5,
        CLS_FBR  = 3'd6,
        CLS_NONE = 3'd7
    } op_class_e;

    typedef struct packed {
        op_class_e cls;
        logic      rdy;
    } cand_t;

    // Partner set of an operate instruction, bounded by register-file ports.
    function automatic logic operate_partner_ok(op_class_e op, op_class_e other);
        if (op == CLS_IOP)
            return (other == CLS_FOP) || (other == CLS_LD) ||
                   (other == CLS_IST) || (other == CLS_IBR);
        if (op == CLS_FOP)
            return (other == CLS_IOP) || (other == CLS_LD) ||
                   (other == CLS_FST) || (other == CLS_FBR);
        return 1'b0;
    endfunction

    function automatic logic may_pair(op_class_e a, op_class_e b);
        return operate_partner_ok(a, b) || operate_partner_ok(b, a);
    endfunction

endpackage

// File: rtl/pair_rules.sv
module pair_rules
    import dual_issue_pkg::*;
(
    input  op_class_e older_cls,
    input  op_class_e younger_cls,
    output logic      legal
);
    always_comb begin
        legal = may_pair(older_cls, younger_cls);
    end
endmodule

// File: rtl/issue_pick.sv
module issue_pick
    import dual_issue_pkg::*;
(
    input  logic      held,
    input  cand_t     held_cand,
    input  logic      pair_valid,
    input  cand_t     older,
    input  cand_t     younger,
    input  logic      legal,
    output logic      fire0,
    output op_class_e cls0,
    output logic      fire1,
    output op_class_e cls1,
    output logic      stall,
    output logic      capture,
    output op_class_e capture_cls
);
    always_comb begin
        fire0       = 1'b0;
        fire1       = 1'b0;
        cls0        = CLS_NONE;
        cls1        = CLS_NONE;
        stall       = 1'b0;
        capture     = 1'b0;
        capture_cls = younger.cls;
        if (held) begin
            cls0  = held_cand.cls;
            fire0 = held_cand.rdy;
            stall = 1'b1;
        end else if (pair_valid && older.cls != CLS_NONE) begin
            cls0    = older.cls;
            cls1    = younger.cls;
            fire0   = older.rdy;
            fire1   = older.rdy && younger.rdy && legal &&
                      (younger.cls != CLS_NONE);
            stall   = !older.rdy;
            capture = older.rdy && (younger.cls != CLS_NONE) && !fire1;
        end
    end
endmodule

// File: rtl/leftover_slot.sv
module leftover_slot
    import dual_issue_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      capture,
    input  op_class_e capture_cls,
    input  logic      drain,
    output logic      valid,
    output op_class_e cls
);
    always_ff @(posedge clk) begin
        if (rst) begin
            valid <= 1'b0;
            cls   <= CLS_NONE;
        end else if (capture) begin
            valid <= 1'b1;
            cls   <= capture_cls;
        end else if (valid && drain) begin
            valid <= 1'b0;
            cls   <= CLS_NONE;
        end
    end
endmodule

// File: rtl/dual_issue_pair.sv
module dual_issue_pair
    import dual_issue_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             pair_valid,
    input  logic [CLS_W-1:0] slot0_cls,
    input  logic             slot0_rdy,
    input  logic [CLS_W-1:0] slot1_cls,
    input  logic             slot1_rdy,
    input  logic             hold_rdy,
    output logic             iss0_fire,
    output logic [CLS_W-1:0] iss0_cls,
    output logic             iss1_fire,
    output logic [CLS_W-1:0] iss1_cls,
    output logic             fe_stall,
    output logic             hold_valid
);
    cand_t     older, younger, held_cand;
    logic      legal, capture;
    op_class_e capture_cls, held_cls, pick0, pick1;

    always_comb begin
        older     = '{cls: op_class_e'(slot0_cls), rdy: slot0_rdy};
        younger   = '{cls: op_class_e'(slot1_cls), rdy: slot1_rdy};
        held_cand = '{cls: held_cls, rdy: hold_rdy};
    end

    pair_rules u_rules (
        .older_cls   (older.cls),
        .younger_cls (younger.cls),
        .legal       (legal)
    );

    issue_pick u_pick (
        .held        (hold_valid),
        .held_cand   (held_cand),
        .pair_valid  (pair_valid),
        .older       (older),
        .younger     (younger),
        .legal       (legal),
        .fire0       (iss0_fire),
        .cls0        (pick0),
        .fire1       (iss1_fire),
        .cls1        (pick1),
        .stall       (fe_stall),
        .capture     (capture),
        .capture_cls (capture_cls)
    );

    leftover_slot u_slot (
        .clk         (clk),
        .rst         (rst),
        .capture     (capture),
        .capture_cls (capture_cls),
        .drain       (iss0_fire),
        .valid       (hold_valid),
        .cls         (held_cls)
    );

    assign iss0_cls = pick0;
    assign iss1_cls = pick1;
endmodule

// File: rtl/dual_issue_pair_chk.sv
module dual_issue_pair_chk
    import dual_issue_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             pair_valid,
    input logic [CLS_W-1:0] slot0_cls,
    input logic [CLS_W-1:0] slot1_cls,
    input logic             hold_rdy,
    input logic             iss0_fire,
    input logic [CLS_W-1:0] iss0_cls,
    input logic             iss1_fire,
    input logic [CLS_W-1:0] iss1_cls,
    input logic             fe_stall,
    input logic             hold_valid
);
    AST_YOUNGER_NEEDS_OLDER: assert property (@(posedge clk) disable iff (rst)
        iss1_fire |-> iss0_fire); // R5

    AST_NO_FORBIDDEN_PAIR: assert property (@(posedge clk) disable iff (rst)
        iss1_fire |-> !(({iss0_cls, iss1_cls} == {CLS_IOP, CLS_FST}) ||
                        ({iss0_cls, iss1_cls} == {CLS_FST, CLS_IOP}) ||
                        ({iss0_cls, iss1_cls} == {CLS_FOP, CLS_IST}) ||
                        ({iss0_cls, iss1_cls} == {CLS_IST, CLS_FOP}))); // R3

    AST_HELD_ALONE: assert property (@(posedge clk) disable iff (rst)
        hold_valid |-> (fe_stall && !iss1_fire && iss1_cls == CLS_NONE)); // R7

    AST_SPLIT_CAPTURES: assert property (@(posedge clk) disable iff (rst)
        (!hold_valid && pair_valid && slot0_cls != CLS_NONE &&
         slot1_cls != CLS_NONE && iss0_fire && !iss1_fire)
        |=> (hold_valid && iss0_cls == $past(slot1_cls))); // R7

    AST_HELD_DRAINS: assert property (@(posedge clk) disable iff (rst)
        (hold_valid && iss0_fire) |=> !hold_valid); // R8

    AST_HELD_WAITS: assert property (@(posedge clk) disable iff (rst)
        (hold_valid && !hold_rdy) |=> (hold_valid && $stable(iss0_cls))); // R8

    AST_HELD_FOLLOWS_READY: assert property (@(posedge clk) disable iff (rst)
        hold_valid |-> (iss0_fire == hold_rdy)); // R8
endmodule

bind dual_issue_pair dual_issue_pair_chk i_chk (
    .clk        (clk),
    .rst        (rst),
    .pair_valid (pair_valid),
    .slot0_cls  (slot0_cls),
    .slot1_cls  (slot1_cls),
    .hold_rdy   (hold_rdy),
    .iss0_fire  (iss0_fire),
    .iss0_cls   (iss0_cls),
    .iss1_fire  (iss1_fire),
    .iss1_cls   (iss1_cls),
    .fe_stall   (fe_stall),
    .hold_valid (hold_valid)
);

// File: tb/test_dual_issue_pair.sv
module test_dual_issue_pair;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       pair_valid = 1'b0;
    logic [2:0] slot0_cls = 3'd7;
    logic       slot0_rdy = 1'b0;
    logic [2:0] slot1_cls = 3'd7;
    logic       slot1_rdy = 1'b0;
    logic       hold_rdy = 1'b0;
    logic       iss0_fire, iss1_fire, fe_stall, hold_valid;
    logic [2:0] iss0_cls, iss1_cls;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    dual_issue_pair i_dual_issue_pair (
        .clk        (clk),
        .rst        (rst),
        .pair_valid (pair_valid),
        .slot0_cls  (slot0_cls),
        .slot0_rdy  (slot0_rdy),
        .slot1_cls  (slot1_cls),
        .slot1_rdy  (slot1_rdy),
        .hold_rdy   (hold_rdy),
        .iss0_fire  (iss0_fire),
        .iss0_cls   (iss0_cls),
        .iss1_fire  (iss1_fire),
        .iss1_cls   (iss1_cls),
        .fe_stall   (fe_stall),
        .hold_valid (hold_valid)
    );

    // Unordered legal pair list from R2.
    function automatic bit pair_expected(int a, int b);
        int lo = (a < b) ? a : b;
        int hi = (a < b) ? b : a;
        case ({lo[3:0], hi[3:0]})
            8'h01, 8'h02, 8'h03, 8'h05, 8'h12, 8'h14, 8'h16: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    task automatic chk(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Drive at the falling edge, sample two ns later, before the rising edge.
    task automatic drive(bit v, int c0, bit r0, int c1, bit r1, bit hr);
        @(negedge clk);
        pair_valid = v;
        slot0_cls  = c0[2:0];
        slot0_rdy  = r0;
        slot1_cls  = c1[2:0];
        slot1_rdy  = r1;
        hold_rdy   = hr;
        #2;
    endtask

    task automatic t_reset();
        drive(0, 7, 0, 7, 0, 0);
        chk("R1", "hold_valid", hold_valid, 0);
        chk("R1", "iss0_fire", iss0_fire, 0);
        chk("R1", "iss1_fire", iss1_fire, 0);
        chk("R1", "fe_stall", fe_stall, 0);
    endtask

    task automatic t_all_pairs();
        for (int a = 0; a < 7; a++) begin
            for (int b = 0; b < 7; b++) begin
                bit ok = pair_expected(a, b);
                string req = ok ? "R2" :
                    ((a == 0 && b == 4) || (a == 4 && b == 0) ||
                     (a == 1 && b == 3) || (a == 3 && b == 1)) ? "R3" : "R4";
                drive(1, a, 1, b, 1, 0);
                chk(req, "hold_valid before", hold_valid, 0);
                chk(req, "iss0_fire", iss0_fire, 1);
                chk(req, "iss1_fire", iss1_fire, ok);
                chk(req, "fe_stall", fe_stall, 0);
                if (!ok) begin
                    drive(1, 0, 1, 1, 1, 1);
                    chk("R7", "hold_valid", hold_valid, 1);
                    chk("R7", "iss0_cls held", iss0_cls, b);
                    chk("R7", "iss1_cls", iss1_cls, 7);
                    chk("R8", "iss0_fire held", iss0_fire, 1);
                    chk("R9", "iss1_fire held", iss1_fire, 0);
                    chk("R7", "fe_stall held", fe_stall, 1);
                end
            end
        end
        drive(0, 7, 0, 7, 0, 0);
        chk("R8", "hold_valid drained", hold_valid, 0);
    endtask

    task automatic t_older_not_ready();
        drive(1, 0, 0, 1, 1, 0);
        chk("R6", "iss0_fire", iss0_fire, 0);
        chk("R6", "iss1_fire", iss1_fire, 0);
        chk("R6", "fe_stall", fe_stall, 1);
        drive(0, 7, 0, 7, 0, 0);
        chk("R6", "hold_valid", hold_valid, 0);
    endtask

    task automatic t_held_wait();
        drive(1, 2, 1, 2, 1, 0);
        chk("R4", "load pair iss1_fire", iss1_fire, 0);
        for (int k = 0; k < 3; k++) begin
            drive(1, 0, 1, 1, 1, 0);
            chk("R8", "hold_valid waiting", hold_valid, 1);
            chk("R8", "iss0_fire waiting", iss0_fire, 0);
            chk("R8", "iss0_cls waiting", iss0_cls, 2);
            chk("R9", "iss1_fire ignored", iss1_fire, 0);
            chk("R9", "fe_stall ignored", fe_stall, 1);
        end
        drive(1, 5, 1, 6, 1, 1);
        chk("R8", "iss0_fire release", iss0_fire, 1);
        chk("R8", "iss0_cls release", iss0_cls, 2);
        drive(0, 7, 0, 7, 0, 0);
        chk("R8", "hold_valid after", hold_valid, 0);
    endtask

    task automatic t_younger_not_ready();
        drive(1, 0, 1, 5, 0, 0);
        chk("R7", "iss0_fire", iss0_fire, 1);
        chk("R5", "iss1_fire", iss1_fire, 0);
        drive(1, 1, 1, 1, 1, 0);
        chk("R7", "hold_valid", hold_valid, 1);
        chk("R7", "iss0_cls", iss0_cls, 5);
        drive(0, 7, 0, 7, 0, 1);
        chk("R8", "iss0_fire", iss0_fire, 1);
        drive(0, 7, 0, 7, 0, 0);
        chk("R8", "hold_valid", hold_valid, 0);
    endtask

    task automatic t_none_slots();
        drive(1, 3, 1, 7, 1, 0);
        chk("R10", "single iss0_fire", iss0_fire, 1);
        chk("R10", "single iss1_fire", iss1_fire, 0);
        chk("R10", "single fe_stall", fe_stall, 0);
        drive(1, 7, 1, 0, 1, 0);
        chk("R10", "single hold_valid", hold_valid, 0);
        chk("R10", "empty iss0_fire", iss0_fire, 0);
        chk("R10", "empty iss1_fire", iss1_fire, 0);
        chk("R10", "empty fe_stall", fe_stall, 0);
        drive(0, 0, 1, 1, 1, 0);
        chk("R10", "invalid iss0_fire", iss0_fire, 0);
        chk("R10", "invalid fe_stall", fe_stall, 0);
        drive(0, 7, 0, 7, 0, 0);
        chk("R10", "hold_valid", hold_valid, 0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_all_pairs();
        t_older_not_ready();
        t_held_wait();
        t_younger_not_ready();
        t_none_slots();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        #(200000 * 8);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule